// File: doc/BRIEF.md
# Configurable Programmable Logic Array

The block evaluates a set of sum-of-products functions over an N-bit input vector. Both planes are held in configuration registers: a bank of K product terms, each built from one two-bit literal code per input, and a bank of M outputs. Each output has a connection mask that picks any subset of the product terms, plus a polarity bit that inverts the OR result. A single product term can feed any number of outputs, so a term common to several functions costs one AND row only.

Configuration is written one row per clock edge through an address, data and write-enable port. Evaluation from `in_vec` to `out_vec` is purely combinational, using the stored configuration. The usual sizing keeps K below 2^N. The default build has 3 inputs, 5 terms and 4 outputs.

Top module: `cfg_pla`

## Requirements
- R1: The literal code for input i of a term sits at bits [2i+1:2i] of that term's row. Code 00 ignores the input. Code 01 requires the input to be 0. Code 10 requires the input to be 1. Code 11 holds the term at 0 whatever the inputs are.
- R2: A term whose literal codes are all 00 evaluates to 1 for every input vector.
- R3: A term is 1 exactly when every one of its literals is satisfied by `in_vec`.
- R4: Before the polarity stage, output j is the OR of every term k whose mask bit k is set. One term may be selected by several outputs at the same time.
- R5: An output whose mask is all zero gives 0 before the polarity stage. When the output's invert bit is 1, the pre-polarity value is complemented.
- R6: On a rising clock edge with `cfg_we` high, the write goes to a row chosen by `cfg_addr`. Address k (0..K-1) loads term k's literal row from `cfg_wdata[2N-1:0]`. Address K+j loads output j: its mask from `cfg_wdata[K-1:0]` and its invert bit from `cfg_wdata[K]`. The outputs follow the new configuration right after that edge, with no further clock.
- R7: Synchronous reset clears every literal to 00, every mask to 0 and every invert bit to 0, so all outputs read 0 for every input vector.
- R8: A write to an address at or above K+M changes no configuration.
- R9: With `cfg_we` low, the configuration holds whatever the address and data do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | $clog2(K+M) | Row address: terms first, then outputs |
| cfg_wdata | input | max(2N, K+1) | Row data |
| in_vec | input | N | Input vector |
| out_vec | output | M | Function outputs after polarity |

## Verification
The hardest case to reach is a term held at 0 by a literal code of 11 while the rest of its row is don't-care. From the ports this looks the same as a term with an empty row, except that the term contributes nothing. To expose it, the bench rewrites a term that one output uses on its own to that pattern and sweeps every input vector. The same sweep runs after the term is cleared to all don't-care, after writes above the last row, and after cycles of address and data traffic with the write enable low. Each sweep is compared against a behavioural model that the bench updates only for legal writes.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [1:0] {
        LIT_ANY  = 2'b00,
        LIT_LOW  = 2'b01,
        LIT_HIGH = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;

    // One literal against one input bit
    function automatic logic lit_pass(input lit_e code, input logic x);
        case (code)
            LIT_ANY:  return 1'b1;
            LIT_LOW:  return ~x;
            LIT_HIGH: return x;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
    parameter int N  = 3,
    parameter int K  = 5,
    parameter int M  = 4,
    parameter int AW = 4,
    parameter int DW = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [DW-1:0]           cfg_wdata,
    output logic [K-1:0][2*N-1:0]   term_row,
    output logic [M-1:0][K-1:0]     out_mask,
    output logic [M-1:0]            out_inv
);
    localparam int ROWS = K + M;

    for (genvar k = 0; k < K; k++) begin : g_term
        always_ff @(posedge clk) begin
            if (rst)
                term_row[k] <= '0;
            else if (cfg_we && cfg_addr == AW'(k))
                term_row[k] <= cfg_wdata[2*N-1:0];
        end
    end

    for (genvar j = 0; j < M; j++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                out_mask[j] <= '0;
                out_inv[j]  <= 1'b0;
            end else if (cfg_we && cfg_addr == AW'(K + j)) begin
                out_mask[j] <= cfg_wdata[K-1:0];
                out_inv[j]  <= cfg_wdata[K];
            end
        end
    end

    logic oob_write;
    assign oob_write = cfg_we && (int'(cfg_addr) >= ROWS);

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (term_row == '0 && out_mask == '0 && out_inv == '0));

    p_oob_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        oob_write |=> ($stable(term_row) && $stable(out_mask) && $stable(out_inv)));

    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(term_row) && $stable(out_mask) && $stable(out_inv)));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N = 3,
    parameter int K = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N-1:0]           in_vec,
    input  logic [K-1:0][2*N-1:0]  term_row,
    output logic [K-1:0]           term_hit
);
    for (genvar k = 0; k < K; k++) begin : g_term
        logic [N-1:0] pass;
        logic [N-1:0] kill;
        for (genvar i = 0; i < N; i++) begin : g_lit
            assign pass[i] = lit_pass(lit_e'(term_row[k][2*i +: 2]), in_vec[i]);
            assign kill[i] = (term_row[k][2*i +: 2] == 2'b11);
        end
        assign term_hit[k] = &pass;

        p_empty_term_true_r2: assert property (@(posedge clk) disable iff (rst)
            (term_row[k] == '0) |-> term_hit[k]);

        p_kill_forces_zero_r1: assert property (@(posedge clk) disable iff (rst)
            (|kill) |-> !term_hit[k]);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int K = 5,
    parameter int M = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [K-1:0]         term_hit,
    input  logic [M-1:0][K-1:0]  out_mask,
    input  logic [M-1:0]         out_inv,
    output logic [M-1:0]         out_vec
);
    for (genvar j = 0; j < M; j++) begin : g_out
        logic sum;
        assign sum        = |(term_hit & out_mask[j]);
        assign out_vec[j] = sum ^ out_inv[j];

        p_empty_mask_r5: assert property (@(posedge clk) disable iff (rst)
            (out_mask[j] == '0) |-> (out_vec[j] == out_inv[j]));

        p_selected_term_r4: assert property (@(posedge clk) disable iff (rst)
            (|(term_hit & out_mask[j])) |-> (out_vec[j] != out_inv[j]));
    end

endmodule

// File: rtl/cfg_pla.sv
module cfg_pla
    import pla_pkg::*;
#(
    parameter int N = 3,
    parameter int K = 5,
    parameter int M = 4,
    localparam int AW = $clog2(K + M),
    localparam int DW = max_int(2 * N, K + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic [N-1:0]   in_vec,
    output logic [M-1:0]   out_vec
);
    logic [K-1:0][2*N-1:0] term_row;
    logic [M-1:0][K-1:0]   out_mask;
    logic [M-1:0]          out_inv;
    logic [K-1:0]          term_hit;

    pla_cfg_store #(.N(N), .K(K), .M(M), .AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .term_row(term_row), .out_mask(out_mask),
        .out_inv(out_inv)
    );

    pla_and_plane #(.N(N), .K(K)) u_and (
        .clk(clk), .rst(rst), .in_vec(in_vec), .term_row(term_row),
        .term_hit(term_hit)
    );

    pla_or_plane #(.K(K), .M(M)) u_or (
        .clk(clk), .rst(rst), .term_hit(term_hit), .out_mask(out_mask),
        .out_inv(out_inv), .out_vec(out_vec)
    );

endmodule

// File: tb/cfg_pla_test.sv
module cfg_pla_test;
    localparam int N  = 3;
    localparam int K  = 5;
    localparam int M  = 4;
    localparam int AW = $clog2(K + M);
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [N-1:0]  in_vec = '0;
    logic [M-1:0]  out_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [2*N-1:0] m_lit  [K];
    logic [K-1:0]   m_mask [M];
    logic           m_inv  [M];

    cfg_pla #(.N(N), .K(K), .M(M)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_vec(in_vec), .out_vec(out_vec)
    );

    always #4 clk = ~clk;

    function automatic logic [M-1:0] model(input logic [N-1:0] v);
        logic [K-1:0] t;
        logic [M-1:0] o;
        for (int k = 0; k < K; k++) begin
            t[k] = 1'b1;
            for (int i = 0; i < N; i++) begin
                case (m_lit[k][2*i +: 2])
                    2'b01:   if (v[i])  t[k] = 1'b0;
                    2'b10:   if (!v[i]) t[k] = 1'b0;
                    2'b11:   t[k] = 1'b0;
                    default: ;
                endcase
            end
        end
        for (int j = 0; j < M; j++) o[j] = (|(t & m_mask[j])) ^ m_inv[j];
        return o;
    endfunction

    task automatic model_clear();
        for (int k = 0; k < K; k++) m_lit[k] = '0;
        for (int j = 0; j < M; j++) begin m_mask[j] = '0; m_inv[j] = 1'b0; end
    endtask

    task automatic check(input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: in=%b actual=%b expected=%b", req, in_vec, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < K) m_lit[addr] = data[2*N-1:0];
        else if (addr < K + M) begin
            m_mask[addr-K] = data[K-1:0];
            m_inv[addr-K]  = data[K];
        end
    endtask

    task automatic sweep(input string req);
        for (int v = 0; v < (1 << N); v++) begin
            @(negedge clk);
            in_vec = N'(v);
            #1;
            check(req, out_vec, model(N'(v)));
        end
    endtask

    // R7: everything cleared after reset
    task automatic t_reset();
        for (int v = 0; v < (1 << N); v++) begin
            @(negedge clk);
            in_vec = N'(v);
            #1;
            check("R7", out_vec, '0);
        end
    endtask

    // R3 R4 R6: reference table, A=in[2] B=in[1] C=in[0]
    task automatic t_reference();
        wr(0, 6'b10_01_00);   // A B'
        wr(1, 6'b00_01_10);   // B' C
        wr(2, 6'b10_00_01);   // A C'
        wr(3, 6'b00_10_01);   // B C'
        wr(4, 6'b10_00_00);   // A
        wr(K+0, {1'b0, 5'b10001});
        wr(K+1, {1'b0, 5'b00101});
        wr(K+2, {1'b0, 5'b01011});
        wr(K+3, {1'b1, 5'b01010});
        sweep("R3");
        // R4: term A B' shared by F0 F1 F2; A=1 B=0 C=1
        @(negedge clk); in_vec = 3'b101; #1;
        check("R4", out_vec, 4'b0111);
    endtask

    // R6: effect visible right after the write edge
    task automatic t_write_timing();
        @(negedge clk); in_vec = 3'b011;
        wr(K+1, {1'b0, 5'b01000});   // F1 = B C'? uses T3 = B C' -> 0 for 011
        #1; check("R6", out_vec, model(3'b011));
        wr(3, 6'b00_10_10);          // T3 = B C -> 1 for 011
        #1; check("R6", out_vec, model(3'b011));
    endtask

    // R2: an all don't-care term is always true
    task automatic t_all_dc();
        wr(4, 6'b00_00_00);
        wr(K+0, {1'b0, 5'b10000});
        sweep("R2");
    endtask

    // R1: code 11 kills the term, code 01/10 select polarity
    task automatic t_kill();
        wr(4, 6'b00_00_11);
        sweep("R1");
        wr(4, 6'b01_00_00);          // A'
        sweep("R1");
    endtask

    // R5: empty mask and inversion
    task automatic t_invert();
        wr(K+2, {1'b1, 5'b00000});
        sweep("R5");
        wr(K+2, {1'b0, 5'b00000});
        sweep("R5");
    endtask

    // R8: writes above the last row change nothing
    task automatic t_oob();
        for (int a = K + M; a < (1 << AW); a++) wr(a, '1);
        sweep("R8");
    endtask

    // R9: traffic with write enable low changes nothing
    task automatic t_idle();
        for (int a = 0; a < K + M; a++) begin
            @(negedge clk);
            cfg_we = 1'b0; cfg_addr = AW'(a); cfg_wdata = '1;
        end
        @(negedge clk);
        sweep("R9");
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reference();
        t_write_timing();
        t_all_dc();
        t_kill();
        t_invert();
        t_oob();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule